// File: doc/BRIEF.md
# Bus Cycle Sequencer for Address/Buffer Register Transfers

This block performs single-byte bus transactions on behalf of a small processor core. The core places an address in a 16-bit address holding register and, for writes, a byte in an 8-bit data buffer register. It then requests one of five cycle kinds: memory read, memory write, port read, port write or interrupt-vector fetch. The sequencer drives the read, write and port-select lines, a chip-select lookup strobe for port cycles and an interrupt-acknowledge strobe. It ends every cycle with a one-cycle completion pulse that reports success or failure.

Port cycles present only the low byte of the address register. They raise the port-select line first, run a chip-select phase, and only after that strobe read or write. Each phase waits for a ready or fault reply from the addressed agent. A per-phase timer ends a phase that gets no reply. On failure the buffer register keeps its old contents.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle, every control line (rd_o, wr_o, cs_o, inta_o, iom_o) and done_o are low, and mar_o and mbr_o are zero.
- R2: mar_load_i and mbr_load_i take effect only while idle_o is high; while a cycle is in progress they are ignored and bus_wdata_o and mar_o keep their values.
- R3: Kind 0 (memory read) strobes rd_o with bus_addr_o equal to the full address register; on ready_i the byte on bus_rdata_i is stored in mbr_o and the cycle succeeds.
- R4: Kind 1 (memory write) strobes wr_o with bus_addr_o equal to the address register and bus_wdata_o equal to mbr_o; on ready_i the cycle succeeds and mbr_o is unchanged.
- R5: Kinds 2 (port read) and 3 (port write) raise iom_o together with cs_o, with bus_addr_o equal to {8'h00, address[7:0]}; after ready_i in that phase, iom_o stays high and rd_o or wr_o is strobed as for memory.
- R6: Kind 4 (vector fetch) strobes inta_o when intc_present_i is high and, on ready_i, stores intc_vec_i in mbr_o; when intc_present_i is low the cycle fails with no strobe and done_o in the cycle after acceptance.
- R7: fault_i in any phase ends the cycle with failure, leaves mbr_o unchanged and starts no further phase; fault_i takes precedence over a simultaneous ready_i.
- R8: A phase that sees neither ready_i nor fault_i for TIMEOUT_CYC cycles fails; ready_i in the last cycle of that window still succeeds.
- R9: At most one of rd_o, wr_o, cs_o, inta_o is high in any cycle, and iom_o is high only during port cycles.
- R10: Each cycle ends with done_o high for exactly one cycle, with ok_o giving the result and all control lines low, after which the block is idle.
- R11: req_valid_i is accepted only while idle_o is high; a request during a cycle is dropped and starts nothing.
- R12: Kind codes 5 to 7 complete with failure and no bus activity, with done_o in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Cycle request |
| req_kind_i | input | 3 | Cycle kind code |
| mar_load_i | input | 1 | Load address register |
| mar_data_i | input | 16 | Address register load value |
| mbr_load_i | input | 1 | Load buffer register |
| mbr_data_i | input | 8 | Buffer register load value |
| mar_o | output | 16 | Address register contents |
| mbr_o | output | 8 | Buffer register contents |
| idle_o | output | 1 | Ready to accept a request |
| done_o | output | 1 | Cycle completion pulse |
| ok_o | output | 1 | Cycle succeeded, valid with done_o |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| iom_o | output | 1 | Port space select |
| cs_o | output | 1 | Chip-select lookup strobe |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| intc_present_i | input | 1 | Interrupt controller fitted |
| intc_vec_i | input | 8 | Vector byte from interrupt controller |
| ready_i | input | 1 | Phase completed by agent |
| fault_i | input | 1 | Phase rejected by agent |

## Verification
The phase timer and the agent's reply can both end a phase in the same cycle. The bench provokes this by holding off ready_i until the sixteenth cycle of a read phase, which is the cycle in which the timer window closes. It requires a successful completion with the read byte stored, and it counts the clock edges to confirm that the reply landed in the expiry cycle. A companion case answers one cycle later and expects a timeout failure at the same latency. Separately, a request and register loads that arrive during a long write must leave the bus values unchanged and must start no second cycle.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    K_MEM_RD = 3'd0,
    K_MEM_WR = 3'd1,
    K_IO_RD  = 3'd2,
    K_IO_WR  = 3'd3,
    K_VEC    = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_XFER,
    S_VEC,
    S_RESP
  } state_e;
endpackage

// File: rtl/bcc_regs.sv
module bcc_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              mar_load_i,
  input  logic [ADDR_W-1:0] mar_data_i,
  input  logic              mbr_load_i,
  input  logic [DATA_W-1:0] mbr_data_i,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_o <= '0;
      mbr_o <= '0;
    end else begin
      if (load_en_i && mar_load_i) mar_o <= mar_data_i;
      if (cap_en_i) mbr_o <= cap_data_i;
      else if (load_en_i && mbr_load_i) mbr_o <= mbr_data_i;
    end
  end
endmodule

// File: rtl/bcc_timer.sv
module bcc_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!active_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = active_i && (cnt_q == LAST);
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_kind_i,
  input  logic       ready_i,
  input  logic       fault_i,
  input  logic       expire_i,
  input  logic       intc_present_i,
  output logic       idle_o,
  output logic       active_o,
  output logic       restart_o,
  output logic       cap_en_o,
  output logic       cap_vec_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       iom_o,
  output logic       cs_o,
  output logic       inta_o,
  output logic       done_o,
  output logic       ok_o
);
  state_e state_q, state_d;
  kind_e  kind_q, kind_d;
  logic   ok_q, ok_d;
  logic   is_read, is_write, is_io;

  assign is_read  = (kind_q == K_MEM_RD) || (kind_q == K_IO_RD);
  assign is_write = (kind_q == K_MEM_WR) || (kind_q == K_IO_WR);
  assign is_io    = (kind_q == K_IO_RD) || (kind_q == K_IO_WR);

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    ok_d      = ok_q;
    cap_en_o  = 1'b0;
    cap_vec_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        kind_d = kind_e'(req_kind_i);
        ok_d   = 1'b0;
        case (kind_e'(req_kind_i))
          K_MEM_RD, K_MEM_WR: state_d = S_XFER;
          K_IO_RD, K_IO_WR:   state_d = S_SEL;
          K_VEC:              state_d = intc_present_i ? S_VEC : S_RESP;
          default:            state_d = S_RESP;
        endcase
      end
      S_SEL: begin
        if (fault_i)       state_d = S_RESP;
        else if (ready_i)  state_d = S_XFER;
        else if (expire_i) state_d = S_RESP;
      end
      S_XFER, S_VEC: begin
        if (fault_i) state_d = S_RESP;
        else if (ready_i) begin
          state_d   = S_RESP;
          ok_d      = 1'b1;
          cap_en_o  = (state_q == S_VEC) || is_read;
          cap_vec_o = (state_q == S_VEC);
        end else if (expire_i) state_d = S_RESP;
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_MEM_RD;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      ok_q    <= ok_d;
    end
  end

  assign idle_o    = (state_q == S_IDLE);
  assign active_o  = (state_q == S_SEL) || (state_q == S_XFER) || (state_q == S_VEC);
  assign restart_o = (state_d != state_q);
  assign cs_o      = (state_q == S_SEL);
  assign rd_o      = (state_q == S_XFER) && is_read;
  assign wr_o      = (state_q == S_XFER) && is_write;
  assign iom_o     = cs_o || ((state_q == S_XFER) && is_io);
  assign inta_o    = (state_q == S_VEC);
  assign done_o    = (state_q == S_RESP);
  assign ok_o      = done_o && ok_q;
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PORT_W      = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic              mar_load_i,
  input  logic [ADDR_W-1:0] mar_data_i,
  input  logic              mbr_load_i,
  input  logic [DATA_W-1:0] mbr_data_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic              idle_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              iom_o,
  output logic              cs_o,
  output logic              inta_o,
  input  logic              intc_present_i,
  input  logic [DATA_W-1:0] intc_vec_i,
  input  logic              ready_i,
  input  logic              fault_i
);
  logic active, restart, expire, cap_en, cap_vec;
  logic [DATA_W-1:0] cap_data;
  logic [ADDR_W-1:0] port_addr;

  bcc_seq u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_kind_i, .ready_i, .fault_i,
    .expire_i(expire), .intc_present_i, .idle_o,
    .active_o(active), .restart_o(restart),
    .cap_en_o(cap_en), .cap_vec_o(cap_vec),
    .rd_o, .wr_o, .iom_o, .cs_o, .inta_o, .done_o, .ok_o
  );

  bcc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .active_i(active), .restart_i(restart), .expire_o(expire)
  );

  assign cap_data = cap_vec ? intc_vec_i : bus_rdata_i;

  bcc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .load_en_i(idle_o),
    .mar_load_i, .mar_data_i, .mbr_load_i, .mbr_data_i,
    .cap_en_i(cap_en), .cap_data_i(cap_data),
    .mar_o, .mbr_o
  );

  generate
    if (PORT_W < ADDR_W) begin : g_port_narrow
      assign port_addr = {{(ADDR_W-PORT_W){1'b0}}, mar_o[PORT_W-1:0]};
    end else begin : g_port_full
      assign port_addr = mar_o;
    end
  endgenerate

  always_comb begin
    if (iom_o)             bus_addr_o = port_addr;
    else if (rd_o || wr_o) bus_addr_o = mar_o;
    else                   bus_addr_o = '0;
  end

  assign bus_wdata_o = wr_o ? mbr_o : '0;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_o,
  input logic              wr_o,
  input logic              cs_o,
  input logic              inta_o,
  input logic              iom_o,
  input logic              done_o,
  input logic              idle_o,
  input logic [ADDR_W-1:0] mar_o,
  input logic [ADDR_W-1:0] bus_addr_o
);
  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_o, wr_o, cs_o, inta_o}));

  a_r10_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(rd_o || wr_o || cs_o || inta_o || iom_o));

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && idle_o));

  a_r5_select_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iom_o) |-> cs_o);

  a_r5_low_byte_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iom_o |-> (bus_addr_o[ADDR_W-1:PORT_W] == '0));

  a_r9_inta_not_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> !iom_o);

  a_r2_mar_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> $stable(mar_o));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !(rd_o || wr_o || cs_o || inta_o || iom_o || done_o));
endmodule

bind bus_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_o(rd_o), .wr_o(wr_o), .cs_o(cs_o),
  .inta_o(inta_o), .iom_o(iom_o), .done_o(done_o), .idle_o(idle_o),
  .mar_o(mar_o), .bus_addr_o(bus_addr_o)
);

// File: tb/bus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic        mar_load = 1'b0, mbr_load = 1'b0;
  logic [15:0] mar_data = '0;
  logic [7:0]  mbr_data = '0;
  logic [15:0] mar, bus_addr;
  logic [7:0]  mbr, bus_wdata;
  logic [7:0]  bus_rdata = '0, intc_vec = '0;
  logic        idle, done, ok, rd, wr, iom, cs, inta;
  logic        intc_present = 1'b1;
  logic        ready = 1'b0, fault = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .mar_load_i(mar_load), .mar_data_i(mar_data), .mbr_load_i(mbr_load),
    .mbr_data_i(mbr_data), .mar_o(mar), .mbr_o(mbr), .idle_o(idle),
    .done_o(done), .ok_o(ok), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .rd_o(rd), .wr_o(wr), .iom_o(iom), .cs_o(cs),
    .inta_o(inta), .intc_present_i(intc_present), .intc_vec_i(intc_vec),
    .ready_i(ready), .fault_i(fault)
  );

  int checks = 0, fails = 0;
  int lat_sel = 1, lat_dat = 1;
  bit flt_sel = 0, flt_dat = 0;
  logic [15:0] mdl_mar = '0;
  logic [7:0]  mdl_mbr = '0;
  bit saw_cs = 0, saw_data = 0;
  int strobe_viol = 0;
  bit finished = 0;

  typedef struct { bit ok; logic [7:0] mbr; string req; } exp_t;
  exp_t exp_q[$];

  task automatic chk(bit cond, string req, string what, int act, int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // responder: agent model
  logic [3:0] prev_pat = '0;
  int pcnt = 0;
  always @(negedge clk) begin
    logic [3:0] pat;
    pat = {rd, wr, cs, inta};
    if (pat != 0) begin
      if (pat == prev_pat) pcnt++;
      else pcnt = 1;
      if (pcnt == 1) begin
        if (cs) begin
          saw_cs = 1;
          chk(iom && bus_addr == {8'h00, mdl_mar[7:0]}, "R5", "select addr",
              bus_addr, {8'h00, mdl_mar[7:0]});
        end else if (rd || wr) begin
          saw_data = 1;
          if (iom) chk(saw_cs && bus_addr == {8'h00, mdl_mar[7:0]}, "R5",
                       "port data after select", bus_addr, {8'h00, mdl_mar[7:0]});
          else chk(bus_addr == mdl_mar, rd ? "R3" : "R4", "mem addr", bus_addr, mdl_mar);
          if (wr) chk(bus_wdata == mdl_mbr, "R4", "write data", bus_wdata, mdl_mbr);
        end else begin
          saw_data = 1;
          chk(!iom, "R6", "inta without port select", iom, 0);
        end
      end
      if (cs) begin
        ready = (lat_sel != 0) && (pcnt == lat_sel) && !flt_sel;
        fault = (lat_sel != 0) && (pcnt == lat_sel) && flt_sel;
      end else begin
        ready = (lat_dat != 0) && (pcnt == lat_dat) && !flt_dat;
        fault = (lat_dat != 0) && (pcnt == lat_dat) && flt_dat;
      end
    end else begin
      pcnt = 0; ready = 0; fault = 0;
    end
    prev_pat = pat;
    if ($countones(pat) > 1 || (iom && !(cs || rd || wr))) strobe_viol++;
  end

  // monitor: scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ok == e.ok, e.req, "result", ok, e.ok);
        chk(mbr == e.mbr, e.req, "buffer after cycle", mbr, e.mbr);
        chk(!(rd || wr || cs || inta || iom), "R10", "lines low at done",
            {rd, wr, cs, inta, iom}, 0);
      end
    end
  end

  task automatic load(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    mar_load = 1; mar_data = a; mbr_load = 1; mbr_data = d;
    @(negedge clk);
    mar_load = 0; mbr_load = 0;
    mdl_mar = a; mdl_mbr = d;
  endtask

  task automatic run(logic [2:0] kind, bit exp_ok, logic [7:0] exp_mbr, int exp_n, string req);
    int n;
    exp_t e;
    e.ok = exp_ok; e.mbr = exp_mbr; e.req = req;
    exp_q.push_back(e);
    saw_cs = 0; saw_data = 0;
    req_valid = 1; req_kind = kind;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 64) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(n == exp_n, req, "latency in edges", n, exp_n);
    mdl_mbr = exp_mbr;
    @(negedge clk);
    chk(idle, "R10", "idle after done", idle, 1);
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_all();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(idle && !done && {rd, wr, cs, inta, iom} == 0, "R1", "reset lines",
        {idle, done, rd, wr, cs, inta, iom}, 7'b1000000);
    chk(mar == 0 && mbr == 0, "R1", "reset registers", {mar, mbr}, 0);

    // R2 loads while idle
    load(16'h1234, 8'h00);
    chk(mar == 16'h1234 && mbr == 8'h00, "R2", "load while idle", mar, 16'h1234);

    // R3 memory read
    bus_rdata = 8'hA5; lat_dat = 1;
    run(3'd0, 1, 8'hA5, 1, "R3");
    bus_rdata = 8'h3C; lat_dat = 3;
    load(16'hF00D, 8'h11);
    run(3'd0, 1, 8'h3C, 3, "R3");

    // R4 memory write
    load(16'h8001, 8'h5A); lat_dat = 2;
    run(3'd1, 1, 8'h5A, 2, "R4");

    // R5 port read and write
    load(16'hBE42, 8'h00); bus_rdata = 8'h77; lat_sel = 1; lat_dat = 2;
    run(3'd2, 1, 8'h77, 3, "R5");
    load(16'h12C3, 8'h99); lat_sel = 2; lat_dat = 1;
    run(3'd3, 1, 8'h99, 3, "R5");

    // R6 vector fetch present / absent
    intc_vec = 8'h21; lat_dat = 2;
    run(3'd4, 1, 8'h21, 2, "R6");
    intc_present = 0;
    run(3'd4, 0, 8'h21, 0, "R6");
    chk(!saw_data, "R6", "no strobe without controller", saw_data, 0);
    intc_present = 1;

    // R7 faults
    bus_rdata = 8'hEE; lat_dat = 2; flt_dat = 1;
    run(3'd0, 0, 8'h21, 2, "R7");
    flt_dat = 0; lat_sel = 1; flt_sel = 1;
    run(3'd2, 0, 8'h21, 1, "R7");
    chk(!saw_data, "R7", "no data phase after select fault", saw_data, 0);
    flt_sel = 0;

    // R8 timeouts, reply in the expiry cycle wins
    lat_dat = 0;
    run(3'd0, 0, 8'h21, 16, "R8");
    lat_dat = 16; bus_rdata = 8'h6B;
    run(3'd0, 1, 8'h6B, 16, "R8");
    lat_dat = 17;
    run(3'd0, 0, 8'h6B, 16, "R8");
    lat_sel = 0; lat_dat = 1;
    run(3'd3, 0, 8'h6B, 16, "R8");
    lat_sel = 1;

    // R2 / R11 interference during a long write
    load(16'h4444, 8'hC7); lat_dat = 8;
    fork
      run(3'd1, 1, 8'hC7, 8, "R11");
      begin
        repeat (3) @(negedge clk);
        mar_load = 1; mar_data = 16'h0BAD; mbr_load = 1; mbr_data = 8'h00;
        req_valid = 1; req_kind = 3'd0;
        @(negedge clk);
        mar_load = 0; mbr_load = 0; req_valid = 0;
        chk(bus_wdata == 8'hC7 && mar == 16'h4444, "R2", "load ignored while busy",
            {mar, bus_wdata}, {16'h4444, 8'hC7});
      end
    join
    repeat (3) begin
      @(negedge clk);
      chk(idle && !(rd || wr || cs || inta), "R11", "dropped request starts nothing",
          {idle, rd, wr, cs, inta}, 5'b10000);
    end
    chk(mar == 16'h4444, "R2", "address kept", mar, 16'h4444);

    // R12 undefined kind
    run(3'd5, 0, 8'hC7, 0, "R12");
    chk(!saw_data && !saw_cs, "R12", "no bus activity", {saw_cs, saw_data}, 0);

    // R9 across the run
    chk(strobe_viol == 0, "R9", "strobe exclusivity", strobe_viol, 0);
    chk(exp_q.size() == 0, "R10", "all completions seen", exp_q.size(), 0);
    finish_all();
  end
endmodule